// File: doc/BRIEF.md
# Auxiliary Memory Bank Mapper

This block decides, for every CPU bus cycle, whether the addressed 256-byte page is served by the main or the auxiliary RAM bank. Reads and writes get separate bank selects, so software can fetch from one bank while storing into the other. Four soft-switch flags steer the choice: auxiliary read, auxiliary write, alternate zero page and a display-store mode. The flags are set and cleared by bus writes to fixed addresses in the I/O page.

The display-store mode overrides the general read and write flags for the display areas. The text page follows the display-page flag. The hi-res page follows the display-page flag only while hi-res is on. Both of those flags come in from the video switch logic. Four status addresses return a flag in the top data bit when they are read. The bank selects are purely combinational from the current page number and the registered flags. A flag written in one cycle steers the mapping from the next cycle on.

Top module: `amb_bank_mapper`

## Requirements
- R1: A bus write sets or clears a flag at the next rising clock edge. The address's bit 0 gives the new value. $C000/$C001 drive display-store, $C002/$C003 auxiliary read, $C004/$C005 auxiliary write and $C008/$C009 alternate zero page. Reads of those addresses, and writes anywhere else, leave every flag unchanged.
- R2: Pages $02–$BF take the read bank from the auxiliary-read flag and the write bank from the auxiliary-write flag (1 = auxiliary), unless R4–R6 apply.
- R3: Pages $00–$01 select auxiliary for both reads and writes exactly when alternate zero page is set, and `altzp` outputs that flag.
- R4: With display-store on and `page2` high, pages $04–$07 select auxiliary for both reads and writes, whatever the read and write flags say.
- R5: With display-store on and `page2` high, pages $20–$3F select auxiliary for both directions when `hires` is high, and main when it is low.
- R6: With display-store on and `page2` low, pages $04–$07 and $20–$3F select main for both directions.
- R7: Pages $C0–$FF always select main for both directions.
- R8: A read of $C013, $C014, $C016 or $C018 raises `stat_hit`. `stat_data` then carries, in bit 7, the auxiliary-read, auxiliary-write, alternate-zero-page or display-store flag respectively, with bits 6..0 zero. In every other cycle `stat_hit` and `stat_data` are 0.
- R9: An active-low reset clears all four flags. While it is asserted, and after it, all selects read main and every status read returns 0 until a flag is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | CPU address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| page2 | input | 1 | Display page 2 flag from video switches |
| hires | input | 1 | Hi-res flag from video switches |
| rd_aux | output | 1 | Read bank select, 1 = auxiliary |
| wr_aux | output | 1 | Write bank select, 1 = auxiliary |
| altzp | output | 1 | Alternate zero page flag, passed on to the high-region logic |
| stat_hit | output | 1 | A status address is being read |
| stat_data | output | 8 | Status byte |

## Verification
The bank selects and the status byte are due in the same cycle as the address that produces them, since no register lies on that path. A flag write changes the outputs only from the cycle after its clock edge. The bench drives each bus cycle just after a rising edge and compares the outputs at the following falling edge. It uses a model whose flags it updates only after that comparison, so a write is first seen in the next cycle. After reset is released, the synchronizer needs two edges, and stimulus starts only after three.

// File: rtl/amb_pkg.sv
package amb_pkg;

  typedef struct packed {
    logic store;
    logic aux_rd;
    logic aux_wr;
    logic alt_zp;
  } amb_flags_t;

  // switch write offsets within the I/O page (bit 0 is the value)
  localparam logic [3:1] SW_STORE  = 3'd0;
  localparam logic [3:1] SW_AUX_RD = 3'd1;
  localparam logic [3:1] SW_AUX_WR = 3'd2;
  localparam logic [3:1] SW_ALT_ZP = 3'd4;

  // status read offsets
  localparam logic [7:0] ST_AUX_RD = 8'h13;
  localparam logic [7:0] ST_AUX_WR = 8'h14;
  localparam logic [7:0] ST_ALT_ZP = 8'h16;
  localparam logic [7:0] ST_STORE  = 8'h18;

  localparam logic [7:0] IO_PAGE = 8'hC0;

endpackage

// File: rtl/amb_switch_regs.sv
module amb_switch_regs
  import amb_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  output amb_flags_t        flags_q
);

  localparam int PAGE_W = ADDR_W - 8;

  amb_flags_t flags_d;
  logic       in_sw_range;
  logic       flag_en;

  assign in_sw_range = (bus_addr[ADDR_W-1:8] == PAGE_W'(IO_PAGE)) &&
                       (bus_addr[7:4] == 4'h0);

  always_comb begin
    flags_d = flags_q;
    flag_en = 1'b0;
    if (bus_wr && in_sw_range) begin
      unique case (bus_addr[3:1])
        SW_STORE:  begin flags_d.store  = bus_addr[0]; flag_en = 1'b1; end
        SW_AUX_RD: begin flags_d.aux_rd = bus_addr[0]; flag_en = 1'b1; end
        SW_AUX_WR: begin flags_d.aux_wr = bus_addr[0]; flag_en = 1'b1; end
        SW_ALT_ZP: begin flags_d.alt_zp = bus_addr[0]; flag_en = 1'b1; end
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else if (flag_en) begin
      flags_q <= flags_d;
    end
  end

endmodule

// File: rtl/amb_page_map.sv
module amb_page_map
  import amb_pkg::*;
#(
  parameter int          PAGE_W    = 8,
  parameter logic [7:0]  ZP_LAST   = 8'h01,
  parameter logic [7:0]  TXT_FIRST = 8'h04,
  parameter logic [7:0]  TXT_LAST  = 8'h07,
  parameter logic [7:0]  HGR_FIRST = 8'h20,
  parameter logic [7:0]  HGR_LAST  = 8'h3F,
  parameter logic [7:0]  RAM_LAST  = 8'hBF
) (
  input  logic [PAGE_W-1:0] page,
  input  amb_flags_t        flags,
  input  logic              page2,
  input  logic              hires,
  output logic              rd_aux,
  output logic              wr_aux
);

  localparam int NDIR = 2;

  logic in_zp, in_ram, in_txt, in_hgr;
  logic dir_flag [NDIR];
  logic dir_sel  [NDIR];

  assign in_zp  = page <= PAGE_W'(ZP_LAST);
  assign in_ram = page <= PAGE_W'(RAM_LAST);
  assign in_txt = (page >= PAGE_W'(TXT_FIRST)) && (page <= PAGE_W'(TXT_LAST));
  assign in_hgr = (page >= PAGE_W'(HGR_FIRST)) && (page <= PAGE_W'(HGR_LAST));

  assign dir_flag[0] = flags.aux_rd;
  assign dir_flag[1] = flags.aux_wr;

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    always_comb begin
      if (in_zp)
        dir_sel[d] = flags.alt_zp;
      else if (!in_ram)
        dir_sel[d] = 1'b0;
      else if (flags.store && in_txt)
        dir_sel[d] = page2;
      else if (flags.store && in_hgr)
        dir_sel[d] = page2 && hires;
      else
        dir_sel[d] = dir_flag[d];
    end
  end

  assign rd_aux = dir_sel[0];
  assign wr_aux = dir_sel[1];

endmodule

// File: rtl/amb_status.sv
module amb_status
  import amb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  amb_flags_t        flags,
  output logic              stat_hit,
  output logic [DATA_W-1:0] stat_data
);

  localparam int PAGE_W = ADDR_W - 8;

  logic io_rd;
  logic flag_bit;

  assign io_rd = bus_rd && (bus_addr[ADDR_W-1:8] == PAGE_W'(IO_PAGE));

  always_comb begin
    stat_hit = 1'b0;
    flag_bit = 1'b0;
    if (io_rd) begin
      unique case (bus_addr[7:0])
        ST_AUX_RD: begin stat_hit = 1'b1; flag_bit = flags.aux_rd; end
        ST_AUX_WR: begin stat_hit = 1'b1; flag_bit = flags.aux_wr; end
        ST_ALT_ZP: begin stat_hit = 1'b1; flag_bit = flags.alt_zp; end
        ST_STORE:  begin stat_hit = 1'b1; flag_bit = flags.store;  end
        default:   ;
      endcase
    end
    stat_data = '0;
    stat_data[DATA_W-1] = flag_bit;
  end

endmodule

// File: rtl/amb_bank_mapper.sv
module amb_bank_mapper
  import amb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic              page2,
  input  logic              hires,
  output logic              rd_aux,
  output logic              wr_aux,
  output logic              altzp,
  output logic              stat_hit,
  output logic [DATA_W-1:0] stat_data
);

  localparam int PAGE_W = ADDR_W - 8;

  logic [1:0]  rst_pipe;
  logic        rst_sync_n;
  amb_flags_t  flags_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  amb_switch_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .flags_q  (flags_q)
  );

  amb_page_map #(.PAGE_W(PAGE_W)) u_map (
    .page   (bus_addr[ADDR_W-1:8]),
    .flags  (flags_q),
    .page2  (page2),
    .hires  (hires),
    .rd_aux (rd_aux),
    .wr_aux (wr_aux)
  );

  amb_status #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_stat (
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .flags     (flags_q),
    .stat_hit  (stat_hit),
    .stat_data (stat_data)
  );

  assign altzp = flags_q.alt_zp;

endmodule

// File: rtl/amb_checker.sv
module amb_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] bus_addr,
  input logic        bus_wr,
  input logic        page2,
  input logic        hires,
  input logic        rd_aux,
  input logic        wr_aux,
  input logic        altzp,
  input logic        stat_hit,
  input logic [7:0]  stat_data,
  input logic        f_store,
  input logic        f_aux_rd
);

  logic [7:0] pg;
  assign pg = bus_addr[15:8];

  AST_AUX_RD_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 16'hC003) |=> f_aux_rd) else $error("aux rd set"); // R1

  AST_ZP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (pg <= 8'h01) |-> (rd_aux == altzp && wr_aux == altzp)) else $error("zp"); // R3

  AST_TEXT_OVERRIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (f_store && page2 && pg >= 8'h04 && pg <= 8'h07) |-> (rd_aux && wr_aux)) else $error("text"); // R4

  AST_HGR_MAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (f_store && !(page2 && hires) && pg >= 8'h20 && pg <= 8'h3F) |-> (!rd_aux && !wr_aux)) else $error("hgr"); // R5

  AST_HIGH_MAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (pg >= 8'hC0) |-> (!rd_aux && !wr_aux)) else $error("high"); // R7

  AST_STAT_FORM: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_data[6:0] == 7'd0) && (stat_hit || stat_data == 8'd0)) else $error("stat"); // R8

endmodule

bind amb_bank_mapper amb_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .page2     (page2),
  .hires     (hires),
  .rd_aux    (rd_aux),
  .wr_aux    (wr_aux),
  .altzp     (altzp),
  .stat_hit  (stat_hit),
  .stat_data (stat_data),
  .f_store   (flags_q.store),
  .f_aux_rd  (flags_q.aux_rd)
);

// File: tb/sim_amb_bank_mapper.sv
`timescale 1ns/1ps
module sim_amb_bank_mapper;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] bus_addr;
  logic        bus_rd, bus_wr, page2, hires;
  logic        rd_aux, wr_aux, altzp, stat_hit;
  logic [7:0]  stat_data;

  int total = 0;
  int bad   = 0;

  bit m_store, m_rd, m_wr, m_zp;

  always #2.5 clk = ~clk;

  amb_bank_mapper u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .page2(page2), .hires(hires), .rd_aux(rd_aux),
    .wr_aux(wr_aux), .altzp(altzp), .stat_hit(stat_hit), .stat_data(stat_data)
  );

  function automatic bit exp_bank(input bit [7:0] pg, input bit wside,
                                  input bit p2, input bit hr);
    if (pg <= 8'h01) return m_zp;
    if (pg >= 8'hC0) return 1'b0;
    if (m_store && pg >= 8'h04 && pg <= 8'h07) return p2;
    if (m_store && pg >= 8'h20 && pg <= 8'h3F) return p2 && hr;
    return wside ? m_wr : m_rd;
  endfunction

  function automatic string region_tag(input bit [7:0] pg, input bit p2);
    if (pg <= 8'h01) return "R3";
    if (pg >= 8'hC0) return "R7";
    if (m_store && ((pg >= 8'h04 && pg <= 8'h07) || (pg >= 8'h20 && pg <= 8'h3F)))
      return p2 ? ((pg >= 8'h20) ? "R5" : "R4") : "R6";
    return "R2";
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input bit [15:0] a, input bit r, input bit w,
                     input bit p2, input bit hr);
    string tg;
    bit    hit;
    bit    fb;
    @(posedge clk); #1;
    bus_addr = a; bus_rd = r; bus_wr = w; page2 = p2; hires = hr;
    @(negedge clk);
    tg = region_tag(a[15:8], p2);
    check({tg, " rd"}, int'(rd_aux), int'(exp_bank(a[15:8], 1'b0, p2, hr)));
    check({tg, " wr"}, int'(wr_aux), int'(exp_bank(a[15:8], 1'b1, p2, hr)));
    check("R3 altzp", int'(altzp), int'(m_zp));
    hit = 1'b0; fb = 1'b0;
    if (r) begin
      case (a)
        16'hC013: begin hit = 1; fb = m_rd;    end
        16'hC014: begin hit = 1; fb = m_wr;    end
        16'hC016: begin hit = 1; fb = m_zp;    end
        16'hC018: begin hit = 1; fb = m_store; end
        default: ;
      endcase
    end
    check("R8 hit", int'(stat_hit), int'(hit));
    check("R8 data", int'(stat_data), int'({fb, 7'd0}));
    if (w && a[15:4] == 12'hC00) begin
      case (a[3:1])
        3'd0: m_store = a[0];
        3'd1: m_rd    = a[0];
        3'd2: m_wr    = a[0];
        3'd4: m_zp    = a[0];
        default: ;
      endcase
    end
  endtask

  task automatic status_all(input string req);
    cyc(16'hC013, 1, 0, 0, 0);
    cyc(16'hC014, 1, 0, 0, 0);
    cyc(16'hC016, 1, 0, 0, 0);
    cyc(16'hC018, 1, 0, 0, 0);
    check({req, " flags"}, int'({m_store, m_rd, m_wr, m_zp}), 0);
  endtask

  initial begin
    #900000;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit [15:0] a;
    void'($urandom(32'd1357));
    rst_n = 1'b0; bus_addr = '0; bus_rd = 0; bus_wr = 0; page2 = 0; hires = 0;
    m_store = 0; m_rd = 0; m_wr = 0; m_zp = 0;
    #1;
    // R9: outputs main and status zero while reset is held
    check("R9 rd during reset", int'(rd_aux), 0);
    check("R9 altzp during reset", int'(altzp), 0);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    status_all("R9");

    // R1: reads of switch addresses must not set flags
    cyc(16'hC003, 1, 0, 0, 0);
    cyc(16'hC009, 1, 0, 0, 0);
    cyc(16'hC013, 1, 0, 0, 0);
    check("R1 read ignored", int'(stat_data), 0);
    // R1: write to C006/C007 range does nothing here
    cyc(16'hC007, 0, 1, 0, 0);
    status_all("R1");
    // R1 set aux read, visible next cycle
    cyc(16'hC003, 0, 1, 0, 0);
    cyc(16'h1234, 1, 0, 0, 0);
    check("R1 aux rd next cycle", int'(rd_aux), 1);
    check("R2 wr stays main", int'(wr_aux), 0);
    // R3 alt zp
    cyc(16'hC009, 0, 1, 0, 0);
    cyc(16'h0180, 1, 0, 0, 0);
    check("R3 zp aux", int'(wr_aux), 1);
    // R4/R5/R6 with store on
    cyc(16'hC001, 0, 1, 0, 0);
    cyc(16'h0500, 1, 0, 1, 0);
    cyc(16'h2100, 1, 0, 1, 0);
    cyc(16'h3F00, 0, 1, 1, 1);
    cyc(16'h0400, 0, 1, 0, 1);
    cyc(16'h0800, 0, 1, 1, 1);
    cyc(16'hD000, 1, 0, 1, 1);
    cyc(16'hFFFF, 1, 0, 1, 1);
    cyc(16'hC018, 1, 0, 0, 0);
    check("R8 store status", int'(stat_data), 8'h80);

    for (int i = 0; i < 4000; i++) begin
      bit r, w;
      case ($urandom % 4)
        0, 1: a = 16'hC000 | 16'($urandom % 16);
        2:    a = 16'hC010 | 16'($urandom % 16);
        default: a = 16'($urandom);
      endcase
      w = ($urandom % 2) == 1;
      r = !w && (($urandom % 2) == 1);
      cyc(a, r, w, 1'b0, 1'b0);
      cyc({8'($urandom % 256), 8'h00}, 1'b1, 1'b0, 1'($urandom), 1'($urandom));
    end

    // R9: reset in mid-run clears flags
    cyc(16'hC001, 0, 1, 0, 0);
    cyc(16'hC005, 0, 1, 0, 0);
    @(posedge clk); #1;
    bus_wr = 0; bus_rd = 0;
    rst_n = 1'b0;
    m_store = 0; m_rd = 0; m_wr = 0; m_zp = 0;
    #2;
    check("R9 wr cleared async", int'(u0.wr_aux), 0);
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    status_all("R9");
    cyc(16'h0500, 0, 1, 1, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule